// File: doc/BRIEF.md
# Decimal-Aware 8-Bit Arithmetic and Logic Unit

This unit does the arithmetic, logic, rotate and decimal-correction work of a small accumulator machine. Each operation takes the accumulator byte, a second operand byte, an optional memory byte and the current zero, auxiliary-carry and carry flags. The unit forms a new accumulator value, a new memory byte when the operation needs one, and new flags. Every class of operation changes only its own share of the flags. The flags it does not touch are copied from the incoming flag inputs.

The outputs are registered. They load on a clock edge only when the operation strobe is high, and otherwise keep their values. Two write-enable outputs tell the surrounding datapath whether the accumulator result and the memory byte are to be written back. Operand fetch and writeback themselves belong to that datapath. Auxiliary carry always means the carry or borrow that passes between bit 3 and bit 4.

Top module: `dec_alu`

## Requirements
- R1: Opcodes 0 (add) and 1 (add plus incoming carry) store the 8-bit sum of A and B. Carry gets the carry out of bit 7, auxiliary carry gets the carry from bit 3 into bit 4, and Z is updated.
- R2: Opcodes 2 (subtract), 3 (subtract with incoming carry as borrow) and 7 (compare) form A minus B. Carry gets the borrow out of bit 7 and auxiliary carry gets the borrow into bit 4. For compare, the result write-enable is 0, the result output equals A, and Z reflects the difference.
- R3: Opcodes 4 (AND), 5 (OR) and 6 (XOR) store the bitwise result and update only Z. Auxiliary carry and carry are copied from their inputs.
- R4: Opcodes 8 (increment A) and 9 (decrement A) update Z and auxiliary carry. Carry is copied from its input.
- R5: Opcodes 10 (rotate right), 11 (rotate left), 12 (rotate right through carry) and 13 (rotate left through carry) shift A by one place. The plain rotates wrap the leaving bit to the other end and also copy it to carry. The carry rotates feed the incoming carry in and send the leaving bit to carry. Z and auxiliary carry are copied from their inputs.
- R6: Opcode 16 (digit rotate right) sets A[3:0] to M[3:0], M[7:4] to A[3:0], and M[3:0] to M[7:4]. Opcode 17 (digit rotate left) sets A[3:0] to M[7:4], M[3:0] to A[3:0], and M[7:4] to M[3:0]. A[7:4] is kept, all flags are copied from their inputs, and both write-enables are 1.
- R7: Opcode 14 (decimal adjust after addition) adds 06h when A[3:0] is above 9 or auxiliary carry is set. It adds 60h and sets carry when A is above 99h or carry is set; otherwise it clears carry. Auxiliary carry gets the bit-3 carry of this addition.
- R8: Opcode 15 (decimal adjust after subtraction) subtracts 06h when auxiliary carry is set and 60h when carry is set. Carry is copied from its input, and auxiliary carry gets the bit-4 borrow of this subtraction.
- R9: Wherever Z is updated, it is 1 exactly when the stored 8-bit result, or the compare difference, is zero.
- R10: Reset clears every output to 0. While the strobe is low, all outputs hold. Unassigned opcodes give result A, memory output equal to the memory input, flags copied from their inputs, and both write-enables 0. For every opcode other than 16 and 17, the memory output equals the memory input and the memory write-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; loads the outputs |
| op_code | input | 5 | Operation select |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| mem_in | input | 8 | Memory byte for digit rotates |
| z_in | input | 1 | Current zero flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| cy_in | input | 1 | Current carry flag |
| res_q | output | 8 | Registered accumulator result |
| mem_q | output | 8 | Registered memory byte result |
| res_we_q | output | 1 | Accumulator write-back enable |
| mem_we_q | output | 1 | Memory write-back enable |
| z_q | output | 1 | Registered zero flag |
| ac_q | output | 1 | Registered auxiliary carry flag |
| cy_q | output | 1 | Registered carry flag |

## Verification
The arithmetic is driven at its carry boundaries. These include FFh+01h, 0Fh+01h, 00h−01h, equal compares, increment of FFh and decrement of 00h. They separate bit-7 carry from bit-3 carry and show that Z follows the stored byte. The decimal adjusts are tried with each correction alone and both together: low digit above nine, value above 99h, and the incoming flags set on an in-range value. Rotates use patterns with both end bits set and each incoming carry, to tell plain rotates from carry rotates. Digit rotates use distinct nibbles in every position, so any swapped nibble shows. A long random run with random incoming flags and idle strobes then checks flag preservation and holding.

// File: rtl/dec_alu_pkg.sv
package dec_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBC = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_CMP  = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_ROR  = 5'd10,
    OP_ROL  = 5'd11,
    OP_RORC = 5'd12,
    OP_ROLC = 5'd13,
    OP_DADD = 5'd14,
    OP_DSUB = 5'd15,
    OP_NROR = 5'd16,
    OP_NROL = 5'd17
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import dec_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              ac,
  output logic              cy
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic              is_sub;
  logic [DATA_W:0]   ext;
  logic [DATA_W-1:0] xo;

  always_comb begin
    b_eff  = b;
    c_eff  = 1'b0;
    is_sub = 1'b0;
    case (op)
      OP_ADDC: c_eff = cin;
      OP_SUB, OP_CMP: is_sub = 1'b1;
      OP_SUBC: begin is_sub = 1'b1; c_eff = cin; end
      OP_INC:  b_eff = DATA_W'(1);
      OP_DEC:  begin b_eff = DATA_W'(1); is_sub = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (is_sub)
      ext = {1'b0, a} - {1'b0, b_eff} - (DATA_W+1)'(c_eff);
    else
      ext = {1'b0, a} + {1'b0, b_eff} + (DATA_W+1)'(c_eff);
  end

  assign res = ext[DATA_W-1:0];
  assign cy  = ext[DATA_W];
  assign xo  = a ^ b_eff ^ res;
  assign ac  = xo[NIB];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import dec_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cy
);
  always_comb begin
    res = a;
    cy  = cin;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ROR:  begin res = {a[0], a[DATA_W-1:1]};        cy = a[0];        end
      OP_ROL:  begin res = {a[DATA_W-2:0], a[DATA_W-1]}; cy = a[DATA_W-1]; end
      OP_RORC: begin res = {cin, a[DATA_W-1:1]};         cy = a[0];        end
      OP_ROLC: begin res = {a[DATA_W-2:0], cin};         cy = a[DATA_W-1]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_bcd_adj.sv
module alu_bcd_adj #(
  parameter int DATA_W = 8
) (
  input  logic              is_sub,
  input  logic [DATA_W-1:0] a,
  input  logic              ac_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              ac,
  output logic              cy
);
  localparam int NIB = DATA_W / 2;
  localparam logic [DATA_W-1:0] LO_FIX  = DATA_W'(6);
  localparam logic [DATA_W-1:0] HI_FIX  = DATA_W'(6) << NIB;
  localparam logic [DATA_W-1:0] DEC_MAX = (DATA_W'(9) << NIB) | DATA_W'(9);
  localparam logic [NIB-1:0]    DIG_MAX = NIB'(9);

  logic [DATA_W-1:0] corr;
  logic [DATA_W-1:0] xo;
  logic              hi_need;

  assign hi_need = (a > DEC_MAX) || cy_in;

  always_comb begin
    corr = '0;
    if (is_sub) begin
      if (ac_in) corr = corr | LO_FIX;
      if (cy_in) corr = corr | HI_FIX;
    end else begin
      if ((a[NIB-1:0] > DIG_MAX) || ac_in) corr = corr | LO_FIX;
      if (hi_need) corr = corr | HI_FIX;
    end
  end

  assign res = is_sub ? (a - corr) : (a + corr);
  assign xo  = a ^ corr ^ res;
  assign ac  = xo[NIB];
  assign cy  = is_sub ? cy_in : hi_need;
endmodule

// File: rtl/alu_nib_rot.sv
module alu_nib_rot #(
  parameter int DATA_W = 8
) (
  input  logic              to_right,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] m,
  output logic [DATA_W-1:0] a_new,
  output logic [DATA_W-1:0] m_new
);
  localparam int NIB = DATA_W / 2;

  logic [NIB-1:0] a_lo, m_lo, m_hi;
  assign a_lo = a[NIB-1:0];
  assign m_lo = m[NIB-1:0];
  assign m_hi = m[DATA_W-1:NIB];

  always_comb begin
    if (to_right) begin
      a_new = {a[DATA_W-1:NIB], m_lo};
      m_new = {a_lo, m_hi};
    end else begin
      a_new = {a[DATA_W-1:NIB], m_hi};
      m_new = {m_lo, a_lo};
    end
  end
endmodule

// File: rtl/dec_alu.sv
module dec_alu
  import dec_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] mem_in,
  input  logic              z_in,
  input  logic              ac_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res_q,
  output logic [DATA_W-1:0] mem_q,
  output logic              res_we_q,
  output logic              mem_we_q,
  output logic              z_q,
  output logic              ac_q,
  output logic              cy_q
);
  localparam int NIB = DATA_W / 2;

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  logic [DATA_W-1:0] as_res, bo_res, bcd_res, nr_a, nr_m;
  logic              as_ac, as_cy, bo_cy, bcd_ac, bcd_cy;

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(cy_in),
    .res(as_res), .ac(as_ac), .cy(as_cy)
  );

  alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(cy_in),
    .res(bo_res), .cy(bo_cy)
  );

  alu_bcd_adj #(.DATA_W(DATA_W)) u_bcd (
    .is_sub(op == OP_DSUB), .a(opnd_a), .ac_in(ac_in), .cy_in(cy_in),
    .res(bcd_res), .ac(bcd_ac), .cy(bcd_cy)
  );

  alu_nib_rot #(.DATA_W(DATA_W)) u_nibrot (
    .to_right(op == OP_NROR), .a(opnd_a), .m(mem_in),
    .a_new(nr_a), .m_new(nr_m)
  );

  logic [DATA_W-1:0] res_d, mem_d;
  logic              rwe_d, mwe_d, z_d, ac_d, cy_d;

  always_comb begin
    res_d = opnd_a;
    mem_d = mem_in;
    rwe_d = 1'b0;
    mwe_d = 1'b0;
    z_d   = z_in;
    ac_d  = ac_in;
    cy_d  = cy_in;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
        res_d = as_res; rwe_d = 1'b1;
        z_d = (as_res == '0); ac_d = as_ac; cy_d = as_cy;
      end
      OP_CMP: begin
        z_d = (as_res == '0); ac_d = as_ac; cy_d = as_cy;
      end
      OP_INC, OP_DEC: begin
        res_d = as_res; rwe_d = 1'b1;
        z_d = (as_res == '0); ac_d = as_ac;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d = bo_res; rwe_d = 1'b1;
        z_d = (bo_res == '0);
      end
      OP_ROR, OP_ROL, OP_RORC, OP_ROLC: begin
        res_d = bo_res; rwe_d = 1'b1; cy_d = bo_cy;
      end
      OP_DADD, OP_DSUB: begin
        res_d = bcd_res; rwe_d = 1'b1;
        z_d = (bcd_res == '0); ac_d = bcd_ac; cy_d = bcd_cy;
      end
      OP_NROR, OP_NROL: begin
        res_d = nr_a; mem_d = nr_m; rwe_d = 1'b1; mwe_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q    <= '0;
      mem_q    <= '0;
      res_we_q <= 1'b0;
      mem_we_q <= 1'b0;
      z_q      <= 1'b0;
      ac_q     <= 1'b0;
      cy_q     <= 1'b0;
    end else if (op_valid) begin
      res_q    <= res_d;
      mem_q    <= mem_d;
      res_we_q <= rwe_d;
      mem_we_q <= mwe_d;
      z_q      <= z_d;
      ac_q     <= ac_d;
      cy_q     <= cy_d;
    end
  end

  a_r2_cmp_no_store: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_CMP) |=> (!res_we_q && res_q == $past(opnd_a)));

  a_r3_logic_keeps_ac_cy: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op inside {OP_AND, OP_OR, OP_XOR})
      |=> (ac_q == $past(ac_in) && cy_q == $past(cy_in)));

  a_r4_incdec_keeps_cy: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op inside {OP_INC, OP_DEC}) |=> (cy_q == $past(cy_in)));

  a_r5_rot_keeps_z_ac: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op inside {OP_ROR, OP_ROL, OP_RORC, OP_ROLC})
      |=> (z_q == $past(z_in) && ac_q == $past(ac_in)));

  a_r6_nib_high_kept: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op inside {OP_NROR, OP_NROL})
      |=> (res_q[DATA_W-1:NIB] == $past(opnd_a[DATA_W-1:NIB]) && mem_we_q
           && z_q == $past(z_in) && ac_q == $past(ac_in) && cy_q == $past(cy_in)));

  a_r8_dsub_keeps_cy: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_DSUB) |=> (cy_q == $past(cy_in)));

  a_r9_zero_matches_result: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_AND, OP_OR,
                            OP_XOR, OP_INC, OP_DEC, OP_DADD, OP_DSUB})
      |=> (z_q == (res_q == '0)));

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(res_q) && $stable(mem_q) && $stable(z_q)
                   && $stable(ac_q) && $stable(cy_q) && $stable(res_we_q)));
endmodule

// File: tb/dec_alu_tb.sv
`timescale 1ns/1ps
module dec_alu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, mem_in = '0;
  logic       z_in = 1'b0, ac_in = 1'b0, cy_in = 1'b0;
  logic [7:0] res_q, mem_q;
  logic       res_we_q, mem_we_q, z_q, ac_q, cy_q;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dec_alu u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .mem_in(mem_in),
    .z_in(z_in), .ac_in(ac_in), .cy_in(cy_in),
    .res_q(res_q), .mem_q(mem_q), .res_we_q(res_we_q), .mem_we_q(mem_we_q),
    .z_q(z_q), .ac_q(ac_q), .cy_q(cy_q)
  );

  int e_r = 0, e_m = 0, e_rw = 0, e_mw = 0, e_z = 0, e_ac = 0, e_cy = 0;
  string tag = "R10";

  function automatic string req_of(int op);
    case (op)
      0, 1: return "R1";
      2, 3, 7: return "R2";
      4, 5, 6: return "R3";
      8, 9: return "R4";
      10, 11, 12, 13: return "R5";
      14: return "R7";
      15: return "R8";
      16, 17: return "R6";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference, integers only
  task automatic model(input int op, input int a, input int b, input int m,
                       input int z, input int ac, input int cy);
    int s, corr, lo;
    e_r = a; e_m = m; e_rw = 0; e_mw = 0; e_z = z; e_ac = ac; e_cy = cy;
    case (op)
      0, 1: begin
        lo = (op == 1) ? cy : 0;
        s = a + b + lo;
        e_r = s & 255; e_cy = (s > 255); e_ac = (((a & 15) + (b & 15) + lo) > 15);
        e_z = (e_r == 0); e_rw = 1;
      end
      2, 3, 7: begin
        lo = (op == 3) ? cy : 0;
        s = a - b - lo;
        e_cy = (s < 0); e_ac = (((a & 15) - (b & 15) - lo) < 0);
        e_z = ((s & 255) == 0);          // R9: compare uses difference
        if (op != 7) begin e_r = s & 255; e_rw = 1; end
      end
      4: begin e_r = a & b; e_z = (e_r == 0); e_rw = 1; end
      5: begin e_r = a | b; e_z = (e_r == 0); e_rw = 1; end
      6: begin e_r = a ^ b; e_z = (e_r == 0); e_rw = 1; end
      8: begin e_r = (a + 1) & 255; e_ac = ((a & 15) == 15); e_z = (e_r == 0); e_rw = 1; end
      9: begin e_r = (a - 1) & 255; e_ac = ((a & 15) == 0);  e_z = (e_r == 0); e_rw = 1; end
      10: begin e_r = (a >> 1) | ((a & 1) << 7); e_cy = a & 1; e_rw = 1; end
      11: begin e_r = ((a << 1) & 255) | (a >> 7); e_cy = a >> 7; e_rw = 1; end
      12: begin e_r = (a >> 1) | (cy << 7); e_cy = a & 1; e_rw = 1; end
      13: begin e_r = ((a << 1) & 255) | cy; e_cy = a >> 7; e_rw = 1; end
      14: begin
        corr = 0;
        if ((a & 15) > 9 || ac) corr += 6;
        if (a > 'h99 || cy) begin corr += 'h60; e_cy = 1; end else e_cy = 0;
        e_r = (a + corr) & 255; e_ac = (((a & 15) + (corr & 15)) > 15);
        e_z = (e_r == 0); e_rw = 1;
      end
      15: begin
        corr = (ac ? 6 : 0) + (cy ? 'h60 : 0);
        e_r = (a - corr) & 255; e_ac = (((a & 15) - (corr & 15)) < 0);
        e_z = (e_r == 0); e_rw = 1;
      end
      16: begin e_r = (a & 'hF0) | (m & 15); e_m = ((a & 15) << 4) | (m >> 4); e_rw = 1; e_mw = 1; end
      17: begin e_r = (a & 'hF0) | (m >> 4); e_m = ((m & 15) << 4) | (a & 15); e_rw = 1; e_mw = 1; end
      default: ;
    endcase
  endtask

  task automatic compare();
    n_cmp++;
    if (res_q !== 8'(e_r) || mem_q !== 8'(e_m) || res_we_q !== 1'(e_rw) ||
        mem_we_q !== 1'(e_mw) || z_q !== 1'(e_z) || ac_q !== 1'(e_ac) || cy_q !== 1'(e_cy)) begin
      n_bad++;
      $display("FAIL %s: got r=%h m=%h rw=%0d mw=%0d z=%0d ac=%0d cy=%0d exp r=%h m=%h rw=%0d mw=%0d z=%0d ac=%0d cy=%0d",
               tag, res_q, mem_q, res_we_q, mem_we_q, z_q, ac_q, cy_q,
               8'(e_r), 8'(e_m), e_rw, e_mw, e_z, e_ac, e_cy);
    end
  endtask

  // apply one cycle of stimulus; the result is compared at the next negedge
  task automatic step(input bit v, input int op, input int a, input int b, input int m,
                      input int z, input int ac, input int cy);
    @(negedge clk);
    compare();
    op_valid = v; op_code = 5'(op); opnd_a = 8'(a); opnd_b = 8'(b); mem_in = 8'(m);
    z_in = z[0]; ac_in = ac[0]; cy_in = cy[0];
    if (v) begin tag = req_of(op); model(op, a, b, m, z, ac, cy); end
    else tag = "R10";
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R10: watchdog expired, got hang expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state (all outputs zero), strobe high during reset is ignored
    op_valid = 1'b1; op_code = 5'd0; opnd_a = 8'h55; opnd_b = 8'h22;
    repeat (3) @(negedge clk);
    compare();
    @(negedge clk);
    rst = 1'b0; op_valid = 1'b0;
    // R1 boundaries
    step(1, 0, 'hFF, 'h01, 0, 0, 0, 0);
    step(1, 0, 'h0F, 'h01, 0, 1, 0, 1);
    step(1, 1, 'h7F, 'h80, 0, 0, 0, 1);
    step(1, 1, 'h12, 'h34, 0, 1, 1, 0);
    // R2 boundaries
    step(1, 2, 'h00, 'h01, 0, 0, 0, 0);
    step(1, 3, 'h10, 'h0F, 0, 0, 0, 1);
    step(1, 7, 'h42, 'h42, 0, 0, 1, 1);
    step(1, 7, 'h10, 'h20, 0, 1, 0, 0);
    // R3 flag preservation
    step(1, 4, 'hF0, 'h0F, 0, 0, 1, 1);
    step(1, 5, 'h00, 'h00, 0, 0, 1, 0);
    step(1, 6, 'hA5, 'hA5, 0, 0, 0, 1);
    // R4
    step(1, 8, 'hFF, 0, 0, 0, 0, 1);
    step(1, 9, 'h00, 0, 0, 1, 1, 0);
    step(1, 9, 'h10, 0, 0, 1, 0, 1);
    // R5
    step(1, 10, 'h81, 0, 0, 1, 1, 0);
    step(1, 11, 'h81, 0, 0, 0, 0, 0);
    step(1, 12, 'h80, 0, 0, 0, 1, 1);
    step(1, 13, 'h01, 0, 0, 1, 0, 0);
    // R7
    step(1, 14, 'h0A, 0, 0, 0, 0, 0);
    step(1, 14, 'h9A, 0, 0, 0, 0, 0);
    step(1, 14, 'hA0, 0, 0, 0, 0, 0);
    step(1, 14, 'h23, 0, 0, 0, 1, 1);
    step(1, 14, 'h45, 0, 0, 1, 0, 0);
    // R8
    step(1, 15, 'h0F, 0, 0, 0, 1, 0);
    step(1, 15, 'h60, 0, 0, 0, 0, 1);
    step(1, 15, 'h05, 0, 0, 0, 1, 1);
    // R6
    step(1, 16, 'hAB, 0, 'hCD, 1, 0, 1);
    step(1, 17, 'hAB, 0, 'hCD, 0, 1, 0);
    // R10 unassigned opcodes and hold
    step(1, 18, 'h77, 'h11, 'h99, 1, 0, 1);
    step(1, 31, 'h01, 'h02, 'h03, 0, 1, 0);
    step(0, 0, 'hFF, 'hFF, 'hFF, 1, 1, 1);
    step(0, 8, 'h00, 'h00, 'h00, 0, 0, 0);
    // random sweep: R1-type mixes across every opcode with random flags
    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(0, 7) != 0), $urandom_range(0, 19), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule